// File: doc/BRIEF.md
# Dual Timebase Prescaler Counter Unit

This block supplies two free-running timebase counters to a multi-channel timer engine. Each counter has its own divider chain, built as clock-enable strobes in the system clock domain. The first timebase takes the system clock through a fixed pre-divider and then a binary prescaler. The pre-divider divides by 32 or by 4. A half-rate override can replace the whole chain with a plain divide-by-2.

The second timebase selects one of two sources. The first is a divide-by-8 of the system clock. The second is an external clock pin, which passes through a two-flop synchronizer and a rising-edge detector. The selected source then feeds a second binary prescaler.

Each counter advances by one on its prescaler's terminal count. With each advance the block raises a one-cycle strobe that is aligned with the new counter value. A halt input freezes all counting. Divider settings are captured into shadow registers each time that counter advances, so a setting changed mid-period takes effect only from the next advance.

Top module: `dual_timebase`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `base1`, `base2`, `tick1` and `tick2` are all zero. The shadowed settings reset to: half-rate off, pre-divide by 32, scale codes 0, external source.
- R2: With `halfRate`=1, `base1` advances once every 2 system clocks, whatever `fineSel` and `scale1` hold.
- R3: With `halfRate`=0 and `fineSel`=0, `base1` advances once every 32·2^k clocks, where k is the value of `scale1` (codes 0,1,2,3 give 32, 64, 128, 256).
- R4: With `halfRate`=0 and `fineSel`=1, `base1` advances once every 4·2^k clocks (codes 0..3 give 4, 8, 16, 32).
- R5: With `srcInt2`=1, `base2` advances once every 8·2^k clocks, where k is the value of `scale2`.
- R6: With `srcInt2`=0, `base2` advances once per 2^k rising edges of `extClk`. A rising edge that is set up before clock edge E is counted at clock edge E+2, and only if that edge completes the prescaler count.
- R7: While `halt`=1, neither counter changes and neither tick is raised. Once `halt` returns to 0, both dividers resume from the phase they held.
- R8: A change to `halfRate`, `fineSel` or `scale1` is applied at the next advance of `base1`, and the period that follows uses the new setting. A change to `srcInt2` or `scale2` is applied in the same way at the next advance of `base2`.
- R9: `tickN` is high for exactly one cycle. That cycle is the one in which `baseN` first shows its incremented value, and `baseN` changes in no other cycle.
- R10: Each counter wraps from 0xFFFF to 0x0000 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | 1 freezes both timebases |
| halfRate | input | 1 | 1 makes the first timebase run at clk/2 |
| fineSel | input | 1 | First pre-divider: 0 selects /32, 1 selects /4 |
| scale1 | input | 2 | First prescaler code k, divide by 2^k |
| srcInt2 | input | 1 | Second source: 0 selects external pin, 1 selects clk/8 |
| scale2 | input | 2 | Second prescaler code k, divide by 2^k |
| extClk | input | 1 | Asynchronous external clock for the second timebase |
| base1 | output | 16 | First timebase count |
| base2 | output | 16 | Second timebase count |
| tick1 | output | 1 | One-cycle strobe on each base1 advance |
| tick2 | output | 1 | One-cycle strobe on each base2 advance |

## Verification
A divider counter or shadow register that holds a wrong value shows up at the ports as an advance that comes early or late. The bench's model then disagrees with `tickN` or `baseN` within one period of the affected timebase. That is at most 256 clocks for the first timebase, and at most 64 clocks or 2^k external edges for the second. A setting that is applied too early or too late shows up in the very period that follows the change. An unsynchronized or double-counted external edge shows up as a phase offset of one or two clocks.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  typedef struct packed {
    logic adv1;
    logic adv2;
  } dtbStrobe_t;
endpackage

// File: rtl/dtb_ctrl.sv
module dtb_ctrl
  import dtb_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int SLOW_DIV = 32,
  parameter int FAST_DIV = 4,
  parameter int HALF_DIV = 2,
  parameter int INT2_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halt,
  input  logic             halfRate,
  input  logic             fineSel,
  input  logic [SEL_W-1:0] scale1,
  input  logic             srcInt2,
  input  logic [SEL_W-1:0] scale2,
  input  logic             extClk,
  output dtbStrobe_t       strobe
);
  localparam int PRE1_W = $clog2(SLOW_DIV);
  localparam int PRE2_W = $clog2(INT2_DIV);
  localparam int PS_W   = (1 << SEL_W) - 1;

  // ---------------- first timebase chain ----------------
  logic             shHalf, shFine;
  logic [SEL_W-1:0] shScale1;
  logic [PRE1_W-1:0] preCnt1, preLim1;
  logic [PS_W-1:0]   psCnt1, psLim1;
  logic pre1Term, ps1Term, adv1;

  always_comb begin
    if (shHalf)      preLim1 = PRE1_W'(HALF_DIV - 1);
    else if (shFine) preLim1 = PRE1_W'(FAST_DIV - 1);
    else             preLim1 = PRE1_W'(SLOW_DIV - 1);
    psLim1 = shHalf ? '0 : PS_W'((1 << shScale1) - 1);
  end

  assign pre1Term = (preCnt1 == preLim1);
  assign ps1Term  = (psCnt1 == psLim1);
  assign adv1     = !halt && pre1Term && ps1Term;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt1  <= '0;
      psCnt1   <= '0;
      shHalf   <= 1'b0;
      shFine   <= 1'b0;
      shScale1 <= '0;
    end else begin
      if (!halt) begin
        if (pre1Term) begin
          preCnt1 <= '0;
          psCnt1  <= ps1Term ? '0 : psCnt1 + 1'b1;
        end else begin
          preCnt1 <= preCnt1 + 1'b1;
        end
      end
      if (adv1) begin
        shHalf   <= halfRate;
        shFine   <= fineSel;
        shScale1 <= scale1;
      end
    end
  end

  // ---------------- second timebase chain ----------------
  logic extMeta, extSync, extPrev, extRise;
  logic             shInt2;
  logic [SEL_W-1:0] shScale2;
  logic [PRE2_W-1:0] preCnt2;
  logic [PS_W-1:0]   psCnt2, psLim2;
  logic pre2Term, ps2Term, adv2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extClk;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end

  assign extRise  = extSync && !extPrev;
  assign psLim2   = PS_W'((1 << shScale2) - 1);
  assign pre2Term = shInt2 ? (preCnt2 == PRE2_W'(INT2_DIV - 1)) : extRise;
  assign ps2Term  = (psCnt2 == psLim2);
  assign adv2     = !halt && pre2Term && ps2Term;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt2  <= '0;
      psCnt2   <= '0;
      shInt2   <= 1'b0;
      shScale2 <= '0;
    end else begin
      if (!halt) begin
        if (shInt2) preCnt2 <= pre2Term ? '0 : preCnt2 + 1'b1;
        if (pre2Term) psCnt2 <= ps2Term ? '0 : psCnt2 + 1'b1;
      end
      if (adv2) begin
        shInt2   <= srcInt2;
        shScale2 <= scale2;
      end
    end
  end

  assign strobe.adv1 = adv1;
  assign strobe.adv2 = adv2;

  // ---------------- assertions ----------------
  assert_half_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (adv1 && halfRate) |=> !strobe.adv1);

  assert_shadow1_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv1 |=> ($stable(shScale1) && $stable(shHalf) && $stable(shFine)));

  assert_shadow2_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv2 |=> ($stable(shScale2) && $stable(shInt2)));

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise);
endmodule

// File: rtl/dtb_datapath.sv
module dtb_datapath
  import dtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dtbStrobe_t       strobe,
  output logic [CNT_W-1:0] base1,
  output logic [CNT_W-1:0] base2,
  output logic             tick1,
  output logic             tick2
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base1 <= '0;
      base2 <= '0;
      tick1 <= 1'b0;
      tick2 <= 1'b0;
    end else begin
      tick1 <= strobe.adv1;
      tick2 <= strobe.adv2;
      if (strobe.adv1) base1 <= base1 + 1'b1;
      if (strobe.adv2) base2 <= base2 + 1'b1;
    end
  end

  assert_step1_R9: assert property (@(posedge clk) disable iff (!rstN)
    tick1 |-> (base1 == CNT_W'($past(base1) + 1'b1)));

  assert_hold1_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tick1 |-> (base1 == $past(base1)));

  assert_step2_R9: assert property (@(posedge clk) disable iff (!rstN)
    tick2 |-> (base2 == CNT_W'($past(base2) + 1'b1)));

  assert_hold2_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tick2 |-> (base2 == $past(base2)));

  assert_wrap1_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tick1 && ($past(base1) == '1)) |-> (base1 == '0));
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import dtb_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int SLOW_DIV = 32,
  parameter int FAST_DIV = 4,
  parameter int HALF_DIV = 2,
  parameter int INT2_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halt,
  input  logic             halfRate,
  input  logic             fineSel,
  input  logic [SEL_W-1:0] scale1,
  input  logic             srcInt2,
  input  logic [SEL_W-1:0] scale2,
  input  logic             extClk,
  output logic [CNT_W-1:0] base1,
  output logic [CNT_W-1:0] base2,
  output logic             tick1,
  output logic             tick2
);
  dtbStrobe_t strobe;

  dtb_ctrl #(
    .SEL_W(SEL_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV),
    .HALF_DIV(HALF_DIV), .INT2_DIV(INT2_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .halt(halt), .halfRate(halfRate),
    .fineSel(fineSel), .scale1(scale1), .srcInt2(srcInt2),
    .scale2(scale2), .extClk(extClk), .strobe(strobe)
  );

  dtb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .base1(base1), .base2(base2), .tick1(tick1), .tick2(tick2)
  );

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(halt) |-> (!tick1 && !tick2));
endmodule

// File: tb/dual_timebase_tb.sv
`timescale 1ns/1ps
module dual_timebase_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, halt = 1'b0, halfRate = 1'b0, fineSel = 1'b0;
  logic srcInt2 = 1'b0, extClk = 1'b0;
  logic [1:0] scale1 = 2'd0, scale2 = 2'd0;
  logic [15:0] base1, base2;
  logic tick1, tick2;

  dual_timebase u_dut (
    .clk(clk), .rstN(rstN), .halt(halt), .halfRate(halfRate),
    .fineSel(fineSel), .scale1(scale1), .srcInt2(srcInt2),
    .scale2(scale2), .extClk(extClk), .base1(base1), .base2(base2),
    .tick1(tick1), .tick2(tick2)
  );

  // behavioural reference: one phase counter per period
  int mPh1, mPs2, mPd2;
  bit mHalf, mFine, mInt2;
  int mSc1, mSc2;
  logic [15:0] mB1, mB2;
  bit mT1, mT2, s1, s2, pv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh1 = 0; mPs2 = 0; mPd2 = 0;
      mHalf = 0; mFine = 0; mInt2 = 0; mSc1 = 0; mSc2 = 0;
      mB1 = 0; mB2 = 0; mT1 = 0; mT2 = 0; s1 = 0; s2 = 0; pv = 0;
    end else begin
      bit rise, ev, inc1, inc2;
      int per1;
      rise = s2 && !pv;
      pv = s2; s2 = s1; s1 = extClk;
      inc1 = 0; inc2 = 0;
      if (!halt) begin
        per1 = mHalf ? 2 : ((mFine ? 4 : 32) << mSc1);
        if (mPh1 == per1 - 1) begin
          inc1 = 1; mPh1 = 0;
          mHalf = halfRate; mFine = fineSel; mSc1 = int'(scale1);
        end else mPh1++;
        ev = mInt2 ? (mPd2 == 7) : rise;
        if (mInt2) mPd2 = (mPd2 + 1) % 8;
        if (ev) begin
          if (mPs2 == (1 << mSc2) - 1) begin
            inc2 = 1; mPs2 = 0; mPd2 = 0;
            mInt2 = srcInt2; mSc2 = int'(scale2);
          end else mPs2++;
        end
      end
      mT1 = inc1; mT2 = inc2;
      if (inc1) mB1 = mB1 + 16'd1;
      if (inc2) mB2 = mB2 + 16'd1;
    end
  end

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit extOn = 0;
  int extPh = 0;

  task automatic check();
    nChecks += 4;
    if (base1 !== mB1) begin nFails++;
      $display("FAIL %s base1 actual=%h expected=%h", curReq, base1, mB1); end
    if (base2 !== mB2) begin nFails++;
      $display("FAIL %s base2 actual=%h expected=%h", curReq, base2, mB2); end
    if (tick1 !== mT1) begin nFails++;
      $display("FAIL R9 tick1 actual=%b expected=%b", tick1, mT1); end
    if (tick2 !== mT2) begin nFails++;
      $display("FAIL R9 tick2 actual=%b expected=%b", tick2, mT2); end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      check();
      if (extOn) begin
        extPh++;
        if (extPh == 3) begin extClk = ~extClk; extPh = 0; end
      end
    end
  endtask

  initial begin
    #(4 * 180000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    curReq = "R1";
    run(4);
    rstN = 1'b1;
    run(2);
    // R3: default /32, then slowest code
    curReq = "R3"; run(700);
    scale1 = 2'd3; curReq = "R8"; run(1100);
    // R4: fine pre-divider, all codes
    fineSel = 1'b1; curReq = "R4";
    for (int k = 0; k < 4; k++) begin scale1 = 2'(k); run(300); end
    // R2: half-rate override ignores the other selects
    halfRate = 1'b1; scale1 = 2'd2; fineSel = 1'b0; curReq = "R2"; run(200);
    fineSel = 1'b1; run(100);
    // R6: external source through synchronizer
    halfRate = 1'b0; scale1 = 2'd0; extOn = 1; curReq = "R6";
    scale2 = 2'd0; run(300);
    scale2 = 2'd2; run(400);
    // R5: internal /8 source, all codes
    srcInt2 = 1'b1; curReq = "R5";
    for (int k = 0; k < 4; k++) begin scale2 = 2'(k); run(250); end
    // R7: halt freezes, resume continues phase
    scale2 = 2'd1; curReq = "R7"; halt = 1'b1; run(120);
    halt = 1'b0; run(200);
    // R10: fastest rate through a full wrap of base1
    extOn = 0; halfRate = 1'b1; curReq = "R10"; run(131100);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule